// File: doc/BRIEF.md
# Logical-Block to Cylinder/Head/Sector Command Splitter

This block accepts one read or write request on a disk drive: a starting logical block, a sector count and a buffer address. It splits the request into chunks that are no longer than a configured sector limit. For each chunk it turns the current logical block into a cylinder, head and sector using the drive geometry. It then sends a six-byte command block out on a valid/ready byte stream.

After the last byte of a chunk, the block waits for a response from the downstream controller. On success it advances the block number, the remaining count and the buffer address, then starts the next chunk. The first error response ends the whole request and reports a failure.

Geometry, the per-drive control byte and the sector limit are captured when the request is accepted. The divisions are done by one shared restoring divider, which is used twice per chunk: first to divide the block by sectors per track, then to divide the track by the head count. The caller must supply nonzero sectors per track, a nonzero head count and a sector limit of at least 1.

Top module: `chs_xfer_splitter`

## Requirements
- R1: After synchronous reset, `busy`, `cmd_valid` and `done_valid` are 0 and `req_ready` is 1.
- R2: The sector field is bits 5:0 of command byte 2 and equals (chunk start block) mod (sectors per track). The track is (chunk start block) / (sectors per track).
- R3: Command byte 1 carries the drive number in bits 7:5 and the head in bits 4:0. The head is track mod head count.
- R4: The cylinder is track / head count. Its bits 9:8 go in bits 7:6 of byte 2, and its bits 7:0 form byte 3.
- R5: Byte 0 is the opcode: 8'h08 for a read and 8'h0A for a write. Byte 5 is the control byte captured with the request.
- R6: Each chunk length, sent in byte 4, is min(remaining count, sector limit). After each successful chunk the start block grows by the chunk length and the remaining count shrinks by it. When the count reaches 0 the request ends with `done_ok`=1.
- R7: `cmd_buf_addr`, valid while a chunk's bytes are offered, starts at the request buffer address. It grows by 512 times the length of each finished chunk.
- R8: After the sixth byte of a chunk, no further command byte is offered until a response (`rsp_valid`) arrives.
- R9: An error response (`rsp_error`=1 with `rsp_valid`) ends the request with `done_ok`=0. No later chunk is sent.
- R10: A request with a zero count completes with `done_ok`=1 and sends no command byte.
- R11: While `cmd_valid` is high and `cmd_ready` low, `cmd_valid` stays high and `cmd_byte` holds. `cmd_last` marks the sixth byte of each block.
- R12: `busy` rises on the edge that accepts a request, and `req_ready` is its inverse. `done_valid` is a one-cycle pulse in the cycle `busy` falls, on the first edge after the final response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_drive | input | 3 | Drive number |
| req_block | input | BLK_W | Starting logical block |
| req_count | input | CNT_W | Number of sectors |
| req_buf | input | ADDR_W | Buffer start address |
| geo_heads | input | 6 | Head count of the drive |
| geo_spt | input | 7 | Sectors per track |
| geo_ctrl | input | 8 | Per-drive control byte |
| cfg_max_sect | input | CNT_W | Largest chunk in sectors |
| cmd_valid | output | 1 | Command byte offered |
| cmd_ready | input | 1 | Command byte taken |
| cmd_byte | output | 8 | Command byte |
| cmd_last | output | 1 | Sixth byte of a block |
| cmd_buf_addr | output | ADDR_W | Buffer address of current chunk |
| rsp_valid | input | 1 | Chunk response |
| rsp_error | input | 1 | Chunk failed |
| busy | output | 1 | Request in progress |
| done_valid | output | 1 | Request finished (pulse) |
| done_ok | output | 1 | Request finished without error |

## Verification
Command bytes have no fixed latency, because each chunk spends a data-dependent number of cycles in the divider. The bench therefore waits for `cmd_valid` with a bounded loop and takes a byte only on a handshake it has itself enabled. It also confirms that a stalled byte is unchanged when it is finally taken.

The request handshake and completion have exact timing, and the bench checks them at those points:
- `busy` is checked at the falling edge right after the accepting edge.
- `done_valid` and `done_ok` are checked at the falling edge that follows the single response cycle, or the accepting cycle for a zero count.

For three falling edges after each sixth byte, the bench confirms that `cmd_valid` stays low.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam int CMD_BYTES   = 6;
  localparam int IDX_W       = 3;
  localparam int HEAD_W      = 6;
  localparam int SPT_W       = 7;
  localparam int SECT_SHIFT  = 9;
  localparam int CYL_W       = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV_SEC,
    ST_DIV_HEAD,
    ST_SEND,
    ST_WAIT
  } chs_state_e;
endpackage

// File: rtl/chs_divider.sv
module chs_divider #(
  parameter int NUM_W = 21,
  parameter int DEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0]  q_r;
  logic [DEN_W:0]    r_r;
  logic [STEP_W-1:0] step_r;
  logic              run_r;
  logic [DEN_W:0]    trial;
  logic              fits;

  assign trial = {r_r[DEN_W-1:0], q_r[NUM_W-1]};
  assign fits  = trial >= {1'b0, den};

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r    <= '0;
      r_r    <= '0;
      step_r <= '0;
      run_r  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_r    <= num;
        r_r    <= '0;
        step_r <= '0;
        run_r  <= 1'b1;
      end else if (run_r) begin
        q_r <= {q_r[NUM_W-2:0], fits};
        r_r <= fits ? (trial - {1'b0, den}) : trial;
        if (step_r == STEP_W'(NUM_W - 1)) begin
          run_r <= 1'b0;
          done  <= 1'b1;
        end else begin
          step_r <= step_r + 1'b1;
        end
      end
    end
  end

  assign quo = q_r;
  assign rem = r_r[DEN_W-1:0];
endmodule

// File: rtl/chs_cmd_pack.sv
module chs_cmd_pack #(
  parameter int CNT_W = 8
) (
  input  logic [7:0]       opcode,
  input  logic [2:0]       drive,
  input  logic [4:0]       head,
  input  logic [9:0]       cyl,
  input  logic [5:0]       sec,
  input  logic [CNT_W-1:0] chunk,
  input  logic [7:0]       ctrl,
  input  logic [2:0]       idx,
  output logic [7:0]       cmd_o
);
  logic [7:0] cnt_byte;

  generate
    if (CNT_W >= 8) begin : g_cnt_trunc
      assign cnt_byte = chunk[7:0];
    end else begin : g_cnt_ext
      assign cnt_byte = {{(8-CNT_W){1'b0}}, chunk};
    end
  endgenerate

  always_comb begin
    case (idx)
      3'd0:    cmd_o = opcode;
      3'd1:    cmd_o = {drive, head};
      3'd2:    cmd_o = {cyl[9:8], sec};
      3'd3:    cmd_o = cyl[7:0];
      3'd4:    cmd_o = cnt_byte;
      default: cmd_o = ctrl;
    endcase
  end
endmodule

// File: rtl/chs_xfer_splitter.sv
module chs_xfer_splitter
  import chs_pkg::*;
#(
  parameter int         BLK_W  = 21,
  parameter int         CNT_W  = 8,
  parameter int         ADDR_W = 24,
  parameter logic [7:0] OP_RD  = 8'h08,
  parameter logic [7:0] OP_WR  = 8'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_drive,
  input  logic [BLK_W-1:0]  req_block,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [ADDR_W-1:0] req_buf,
  input  logic [5:0]        geo_heads,
  input  logic [6:0]        geo_spt,
  input  logic [7:0]        geo_ctrl,
  input  logic [CNT_W-1:0]  cfg_max_sect,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_byte,
  output logic              cmd_last,
  output logic [ADDR_W-1:0] cmd_buf_addr,
  input  logic              rsp_valid,
  input  logic              rsp_error,
  output logic              busy,
  output logic              done_valid,
  output logic              done_ok
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CMD_BYTES - 1);

  chs_state_e        state_r;
  logic              wr_r;
  logic [2:0]        drv_r;
  logic [BLK_W-1:0]  blk_r, trk_r;
  logic [CNT_W-1:0]  left_r, chunk_r, max_r, chunk_w;
  logic [ADDR_W-1:0] buf_r;
  logic [HEAD_W-1:0] heads_r;
  logic [SPT_W-1:0]  spt_r;
  logic [7:0]        ctrl_r;
  logic [5:0]        sec_r;
  logic [4:0]        head_r;
  logic [CYL_W-1:0]  cyl_r;
  logic [IDX_W-1:0]  idx_r;
  logic              div_start_r, div_done;
  logic [BLK_W-1:0]  div_num, div_quo;
  logic [SPT_W-1:0]  div_den, div_rem;
  logic              xfer;

  assign chunk_w = (left_r < max_r) ? left_r : max_r;
  assign div_num = (state_r == ST_DIV_HEAD) ? trk_r : blk_r;
  assign div_den = (state_r == ST_DIV_HEAD) ? {1'b0, heads_r} : spt_r;
  assign xfer    = cmd_valid && cmd_ready;

  chs_divider #(.NUM_W(BLK_W), .DEN_W(SPT_W)) div_i (
    .clk(clk), .rst(rst), .start(div_start_r), .num(div_num), .den(div_den),
    .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  chs_cmd_pack #(.CNT_W(CNT_W)) pack_i (
    .opcode(wr_r ? OP_WR : OP_RD), .drive(drv_r), .head(head_r), .cyl(cyl_r),
    .sec(sec_r), .chunk(chunk_r), .ctrl(ctrl_r), .idx(idx_r), .cmd_o(cmd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_r     <= ST_IDLE;
      busy        <= 1'b0;
      done_valid  <= 1'b0;
      done_ok     <= 1'b0;
      div_start_r <= 1'b0;
      wr_r <= 1'b0; drv_r <= '0; blk_r <= '0; trk_r <= '0;
      left_r <= '0; chunk_r <= '0; max_r <= '0; buf_r <= '0;
      heads_r <= '0; spt_r <= '0; ctrl_r <= '0;
      sec_r <= '0; head_r <= '0; cyl_r <= '0; idx_r <= '0;
    end else begin
      done_valid  <= 1'b0;
      div_start_r <= 1'b0;
      case (state_r)
        ST_IDLE: if (req_valid) begin
          wr_r <= req_write; drv_r <= req_drive; blk_r <= req_block;
          left_r <= req_count; buf_r <= req_buf; max_r <= cfg_max_sect;
          heads_r <= geo_heads; spt_r <= geo_spt; ctrl_r <= geo_ctrl;
          if (req_count == '0) begin
            done_valid <= 1'b1;
            done_ok    <= 1'b1;
          end else begin
            busy        <= 1'b1;
            div_start_r <= 1'b1;
            state_r     <= ST_DIV_SEC;
          end
        end
        ST_DIV_SEC: if (div_done) begin
          sec_r       <= div_rem[5:0];
          trk_r       <= div_quo;
          div_start_r <= 1'b1;
          state_r     <= ST_DIV_HEAD;
        end
        ST_DIV_HEAD: if (div_done) begin
          head_r  <= div_rem[4:0];
          cyl_r   <= div_quo[CYL_W-1:0];
          chunk_r <= chunk_w;
          idx_r   <= '0;
          state_r <= ST_SEND;
        end
        ST_SEND: if (xfer) begin
          if (idx_r == LAST_IDX) state_r <= ST_WAIT;
          else                   idx_r   <= idx_r + 1'b1;
        end
        ST_WAIT: if (rsp_valid) begin
          if (rsp_error || left_r == chunk_r) begin
            done_valid <= 1'b1;
            done_ok    <= !rsp_error;
            busy       <= 1'b0;
            state_r    <= ST_IDLE;
          end else begin
            div_start_r <= 1'b1;
            state_r     <= ST_DIV_SEC;
          end
          blk_r  <= blk_r + BLK_W'(chunk_r);
          left_r <= left_r - chunk_r;
          buf_r  <= buf_r + (ADDR_W'(chunk_r) << SECT_SHIFT);
        end
        default: state_r <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = !busy;
  assign cmd_valid    = (state_r == ST_SEND);
  assign cmd_last     = cmd_valid && (idx_r == LAST_IDX);
  assign cmd_buf_addr = buf_r;
endmodule

// File: rtl/chs_xfer_splitter_chk.sv
module chs_xfer_splitter_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       busy,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_byte,
  input logic       cmd_last,
  input logic       rsp_valid,
  input logic       rsp_error,
  input logic       done_valid,
  input logic       done_ok
);
  logic [2:0] seen_r;
  logic       await_r;

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      seen_r  <= '0;
      await_r <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) seen_r <= (seen_r == 3'd5) ? 3'd0 : seen_r + 3'd1;
      if (cmd_valid && cmd_ready && seen_r == 3'd5) await_r <= 1'b1;
      else if (rsp_valid) await_r <= 1'b0;
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte)); // R11
  AST_LAST_SIXTH: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_last == (seen_r == 3'd5))); // R11
  AST_WAIT_RSP: assert property (@(posedge clk) disable iff (rst)
    await_r |-> !cmd_valid); // R8
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (rst)
    await_r && rsp_valid && rsp_error |=> done_valid && !done_ok); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_valid); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R12
  AST_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_valid); // R12
  AST_RISE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid)); // R12
endmodule

bind chs_xfer_splitter chs_xfer_splitter_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
  .cmd_last(cmd_last), .rsp_valid(rsp_valid), .rsp_error(rsp_error),
  .done_valid(done_valid), .done_ok(done_ok)
);

// File: tb/chs_xfer_splitter_tb.sv
module chs_xfer_splitter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 0, req_ready, req_write = 0;
  logic [2:0]  req_drive = 0;
  logic [20:0] req_block = 0;
  logic [7:0]  req_count = 0;
  logic [23:0] req_buf = 0;
  logic [5:0]  geo_heads = 1;
  logic [6:0]  geo_spt = 1;
  logic [7:0]  geo_ctrl = 0, cfg_max_sect = 1;
  logic        cmd_valid, cmd_ready = 0, cmd_last;
  logic [7:0]  cmd_byte;
  logic [23:0] cmd_buf_addr;
  logic        rsp_valid = 0, rsp_error = 0, busy, done_valid, done_ok;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chs_xfer_splitter dut_i (.*);

  typedef struct packed {
    logic wr; logic [7:0] maxs; logic [6:0] spt; logic [5:0] heads;
    logic [7:0] cnt; logic [20:0] blk;
  } vec_t;
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd1,  7'd17, 6'd4,  8'd1,  21'd0},
    '{1'b1, 8'd1,  7'd17, 6'd4,  8'd3,  21'd100},
    '{1'b0, 8'd64, 7'd17, 6'd16, 8'd5,  21'd190494},
    '{1'b1, 8'd64, 7'd63, 6'd2,  8'd70, 21'd128960},
    '{1'b0, 8'd64, 7'd1,  6'd32, 8'd2,  21'd1000},
    '{1'b1, 8'd2,  7'd17, 6'd1,  8'd2,  21'd16}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k, input bit wr, input int drv,
      input int heads, input int spt, input int blk, input int chunk, input int ctrl);
    int trk, sec, hd, cyl;
    trk = blk / spt; sec = blk % spt; hd = trk % heads; cyl = trk / heads;
    case (k)
      0: return wr ? 8'h0A : 8'h08;
      1: return 8'((drv << 5) | (hd & 31));
      2: return 8'((((cyl >> 8) & 3) << 6) | (sec & 63));
      3: return 8'(cyl & 255);
      4: return 8'(chunk);
      default: return 8'(ctrl);
    endcase
  endfunction

  task automatic get_byte(input bit stall, output logic [7:0] v, output bit got);
    logic [7:0] held = 0;
    bit have_held = 0;
    got = 0; v = 0;
    for (int n = 0; n < 600 && !got; n++) begin
      @(negedge clk);
      cmd_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (cmd_valid) begin
        if (have_held) chk(cmd_byte == held, "R11 stalled byte held", cmd_byte, held);
        if (cmd_ready) begin v = cmd_byte; got = 1; end
        else begin held = cmd_byte; have_held = 1; end
      end
    end
  endtask

  task automatic run_req(input vec_t v, input int err_at, input bit stall,
      input int drv, input int ctrl, input int bufa);
    int left, b, ba, chunk, ch_i;
    logic [7:0] got_b, e;
    bit got, quiet;
    @(negedge clk);
    req_valid = 1; req_write = v.wr; req_drive = 3'(drv); req_block = v.blk;
    req_count = v.cnt; req_buf = 24'(bufa); geo_heads = v.heads; geo_spt = v.spt;
    geo_ctrl = 8'(ctrl); cfg_max_sect = v.maxs;
    #1 chk(req_ready == 1'b1, "R12 req_ready while idle", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    if (v.cnt == 0) begin
      chk(done_valid && done_ok, "R10 zero count done ok", {done_valid, done_ok}, 2'b11);
      quiet = 1;
      repeat (10) begin @(negedge clk); if (cmd_valid) quiet = 0; end
      chk(quiet, "R10 no command byte", !quiet, 0);
      return;
    end
    chk(busy == 1'b1, "R12 busy after accept", busy, 1);
    left = v.cnt; b = v.blk; ba = bufa; ch_i = 0;
    while (left > 0) begin
      chunk = (left < v.maxs) ? left : v.maxs;
      for (int k = 0; k < 6; k++) begin
        e = exp_byte(k, v.wr, drv, v.heads, v.spt, b, chunk, ctrl);
        get_byte(stall, got_b, got);
        chk(got, "R6 command byte arrives", got, 1);
        if (!got) return;
        case (k)
          0: begin
               chk(got_b == e, "R5 opcode byte", got_b, e);
               chk(cmd_buf_addr == 24'(ba), "R7 buffer address", cmd_buf_addr, ba);
             end
          1: chk(got_b == e, "R3 drive/head byte", got_b, e);
          2: chk(got_b == e, "R2 R4 cyl-high/sector byte", got_b, e);
          3: chk(got_b == e, "R4 cylinder low byte", got_b, e);
          4: chk(got_b == e, "R6 chunk count byte", got_b, e);
          default: begin
               chk(got_b == e, "R5 control byte", got_b, e);
               chk(cmd_last == 1'b1, "R11 last marker", cmd_last, 1);
             end
        endcase
      end
      quiet = 1;
      repeat (3) begin @(negedge clk); #1; if (cmd_valid) quiet = 0; end
      chk(quiet, "R8 no byte before response", !quiet, 0);
      rsp_valid = 1; rsp_error = (ch_i == err_at);
      @(negedge clk);
      rsp_valid = 0;
      if (rsp_error) begin
        rsp_error = 0;
        chk(done_valid && !done_ok, "R9 error ends request", {done_valid, done_ok}, 2'b10);
        quiet = 1;
        repeat (120) begin @(negedge clk); #1; if (cmd_valid) quiet = 0; end
        chk(quiet && !busy, "R9 no later chunk", {quiet, busy}, 2'b10);
        return;
      end
      left -= chunk; b += chunk; ba += chunk * 512; ch_i++;
      if (left == 0)
        chk(done_valid && done_ok && !busy, "R6 R12 done ok after last chunk",
            {done_valid, done_ok, busy}, 3'b110);
    end
    @(negedge clk);
    chk(!done_valid, "R12 done pulse one cycle", done_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !cmd_valid && !done_valid && req_ready, "R1 reset state",
        {busy, cmd_valid, done_valid, req_ready}, 4'b0001);
    for (int i = 0; i < NVEC; i++) run_req(VECS[i], -1, 1'b0, i % 8, 8'h05 + i, 24'h1000 * i);
    run_req('{1'b0, 8'd64, 7'd17, 6'd4, 8'd0, 21'd55}, -1, 1'b0, 2, 8'h00, 24'h0);
    run_req('{1'b1, 8'd1, 7'd17, 6'd4, 8'd3, 21'd400}, 1, 1'b0, 1, 8'h02, 24'h8000);
    run_req('{1'b0, 8'd4, 7'd17, 6'd8, 8'd6, 21'd16}, -1, 1'b1, 7, 8'hA5, 24'h400);
    run_req('{1'b0, 8'd1, 7'd17, 6'd4, 8'd2, 21'd10}, 0, 1'b0, 0, 8'h00, 24'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule